// File: doc/BRIEF.md
# MAC Row Redundancy Steering Controller

This block sits between a processing-in-memory multiply-accumulate array and the adder tree that weights and sums its per-lane results. Each cycle it receives the row address being computed, one result code per lane from the core row, and one result code from a spare row. When spare steering is switched on, a valid repair entry is loaded, and the row address equals the stored failure address, the result of the one lane named by the entry is replaced by the spare row's result. Every other lane passes its core result unchanged.

The repair works in place, one lane at a time. No result moves to a neighbouring lane, so each lane keeps the bit-position weight the adder gives it. A small registered write port loads the failure address, the lane to replace and a valid flag. The address comparison and lane decode are combinational. The steered set of results is registered, so it appears one cycle after the input, with a valid flag beside it.

Top module: `mac_spare_steer`

## Requirements
- R1: While reset is asserted and just after it, `out_valid` is 0, `out_res` is all zeros, and the repair entry is invalid with failure address 0 and lane 0.
- R2: `out_valid` is asserted exactly one clock cycle after a cycle in which `in_valid` is high, and is low otherwise. Each accepted input produces exactly one output.
- R3: If the row address does not equal the stored failure address, every lane of `out_res` equals the matching lane of `core_res`.
- R4: If `spare_en` is 1, the entry is valid and `row_addr` equals the stored address, then the lane given by the stored lane index carries `spare_res`. All other lanes carry their `core_res` values.
- R5: If `spare_en` is 0, no lane is substituted, even when the address matches a valid entry.
- R6: If the stored entry's valid flag is 0, no lane is substituted, even when `spare_en` is 1 and the address matches.
- R7: Lane i occupies bits [i*RES_W +: RES_W] in both `core_res` and `out_res`. Substitution never moves a result to another lane, including for lane 0 and lane LANES-1.
- R8: A write on `cfg_we` loads `cfg_addr`, `cfg_lane` and `cfg_valid` at the clock edge. Inputs presented from the next cycle on use the new entry, and a later write fully replaces the earlier one.
- R9: In a cycle with `in_valid` low, `out_res` keeps its previous value on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the repair entry |
| cfg_addr | input | ADDR_W | Failure row address to store |
| cfg_lane | input | LANE_W | Lane index to replace |
| cfg_valid | input | 1 | Valid flag to store |
| spare_en | input | 1 | Enables spare steering |
| in_valid | input | 1 | Input results present this cycle |
| row_addr | input | ADDR_W | Row address of the current results |
| core_res | input | LANES*RES_W | Core row results, lane i at bits [i*RES_W +: RES_W] |
| spare_res | input | RES_W | Spare row result |
| out_valid | output | 1 | Output results valid |
| out_res | output | LANES*RES_W | Steered results to the adder |

## Verification
Every steered result is due one clock edge after its input cycle. The driver applies inputs on the falling edge and pushes the expected lane vector into a queue. The monitor samples a quarter period after each rising edge and pops exactly one item whenever the previous cycle carried an input. An empty queue then means `out_valid` must be low. Configuration writes update the bench's own copy of the entry in the same cycle the write is issued, so the next input uses the new entry. After idle cycles the output is compared with the last delivered vector.

// File: rtl/mss_pkg.sv
package mss_pkg;
  typedef enum logic {
    SRC_CORE  = 1'b0,
    SRC_SPARE = 1'b1
  } lane_src_e;
endpackage

// File: rtl/mss_entry_reg.sv
module mss_entry_reg #(
  parameter int ADDR_W = 9,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic              wr_valid,
  output logic [ADDR_W-1:0] ent_addr,
  output logic [LANE_W-1:0] ent_lane,
  output logic              ent_valid
);
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [LANE_W-1:0] lane_d, lane_q;
  logic              vld_d, vld_q;

  always_comb begin
    addr_d = addr_q;
    lane_d = lane_q;
    vld_d  = vld_q;
    if (wr_en) begin
      addr_d = wr_addr;
      lane_d = wr_lane;
      vld_d  = wr_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lane_q <= '0;
      vld_q  <= 1'b0;
    end else if (wr_en) begin
      addr_q <= addr_d;
      lane_q <= lane_d;
      vld_q  <= vld_d;
    end
  end

  assign ent_addr  = addr_q;
  assign ent_lane  = lane_q;
  assign ent_valid = vld_q;

  assert_entry_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_addr == $past(wr_addr)) && (ent_lane == $past(wr_lane))
              && (ent_valid == $past(wr_valid)));
  assert_entry_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ent_addr) && $stable(ent_lane) && $stable(ent_valid));
endmodule

// File: rtl/mss_lane_decoder.sv
module mss_lane_decoder #(
  parameter int LANES  = 8,
  parameter int ADDR_W = 9,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spare_en,
  input  logic [ADDR_W-1:0] row_addr,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [LANE_W-1:0] ent_lane,
  input  logic              ent_valid,
  output logic [LANES-1:0]  lane_sel
);
  logic hit;

  always_comb begin
    hit = spare_en && ent_valid && (row_addr == ent_addr);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_dec
    always_comb begin
      lane_sel[i] = hit && (ent_lane == LANE_W'(i));
    end
  end

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_sel));
  assert_gate_spare_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !spare_en |-> (lane_sel == '0));
  assert_gate_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_valid |-> (lane_sel == '0));
  assert_gate_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr != ent_addr) |-> (lane_sel == '0));
endmodule

// File: rtl/mss_lane_mux.sv
module mss_lane_mux
  import mss_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             sel,
  input  logic [RES_W-1:0] core_val,
  input  logic [RES_W-1:0] spare_val,
  output logic [RES_W-1:0] lane_val
);
  lane_src_e src;

  always_comb begin
    src = sel ? SRC_SPARE : SRC_CORE;
    unique case (src)
      SRC_SPARE: lane_val = spare_val;
      default:   lane_val = core_val;
    endcase
  end
endmodule

// File: rtl/mac_spare_steer.sv
module mac_spare_steer #(
  parameter int LANES  = 8,
  parameter int RES_W  = 8,
  parameter int ADDR_W = 9,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [LANE_W-1:0]      cfg_lane,
  input  logic                   cfg_valid,
  input  logic                   spare_en,
  input  logic                   in_valid,
  input  logic [ADDR_W-1:0]      row_addr,
  input  logic [LANES*RES_W-1:0] core_res,
  input  logic [RES_W-1:0]       spare_res,
  output logic                   out_valid,
  output logic [LANES*RES_W-1:0] out_res
);
  localparam int BUS_W = LANES * RES_W;

  logic [ADDR_W-1:0] ent_addr;
  logic [LANE_W-1:0] ent_lane;
  logic              ent_valid;
  logic [LANES-1:0]  lane_sel;
  logic [BUS_W-1:0]  steered;
  logic [BUS_W-1:0]  res_d, res_q;
  logic              vld_d, vld_q;

  mss_entry_reg #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_entry (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_lane(cfg_lane), .wr_valid(cfg_valid),
    .ent_addr(ent_addr), .ent_lane(ent_lane), .ent_valid(ent_valid)
  );

  mss_lane_decoder #(.LANES(LANES), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .spare_en(spare_en), .row_addr(row_addr),
    .ent_addr(ent_addr), .ent_lane(ent_lane), .ent_valid(ent_valid),
    .lane_sel(lane_sel)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    mss_lane_mux #(.RES_W(RES_W)) u_mux (
      .sel(lane_sel[i]),
      .core_val(core_res[i*RES_W +: RES_W]),
      .spare_val(spare_res),
      .lane_val(steered[i*RES_W +: RES_W])
    );

    assert_lane_spare_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && lane_sel[i] |=> out_res[i*RES_W +: RES_W] == $past(spare_res));
    assert_lane_core_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !lane_sel[i] |=>
        out_res[i*RES_W +: RES_W] == $past(core_res[i*RES_W +: RES_W]));
  end

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) begin
      res_d = steered;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) begin
        res_q <= res_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_res   = res_q;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_res));
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !out_valid && (out_res == '0));
endmodule

// File: tb/mac_spare_steer_tb_top.sv
`timescale 1ns/1ps
module mac_spare_steer_tb_top;
  localparam int LANES  = 8;
  localparam int RES_W  = 8;
  localparam int ADDR_W = 9;
  localparam int LANE_W = 3;
  localparam int BUS_W  = LANES * RES_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we, cfg_valid, spare_en, in_valid;
  logic [ADDR_W-1:0] cfg_addr, row_addr;
  logic [LANE_W-1:0] cfg_lane;
  logic [BUS_W-1:0]  core_res, out_res;
  logic [RES_W-1:0]  spare_res;
  logic              out_valid;

  always #10 clk = ~clk;

  mac_spare_steer #(.LANES(LANES), .RES_W(RES_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_lane(cfg_lane), .cfg_valid(cfg_valid), .spare_en(spare_en),
    .in_valid(in_valid), .row_addr(row_addr), .core_res(core_res),
    .spare_res(spare_res), .out_valid(out_valid), .out_res(out_res)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit mon_on   = 0;

  logic [BUS_W-1:0] exp_q[$];
  string            tag_q[$];
  logic [BUS_W-1:0] last_out = '0;

  logic [ADDR_W-1:0] m_addr  = '0;
  logic [LANE_W-1:0] m_lane  = '0;
  logic              m_valid = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [ADDR_W-1:0] a, input logic [LANE_W-1:0] l,
                     input logic v);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_lane = l; cfg_valid = v;
    m_addr = a; m_lane = l; m_valid = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drives one input on the current falling edge; caller waits for it.
  task automatic drive(input logic [ADDR_W-1:0] r, input logic en,
                       input logic [BUS_W-1:0] c, input logic [RES_W-1:0] s,
                       input string req);
    logic [BUS_W-1:0] e;
    e = c;
    if (en && m_valid && (r == m_addr))
      e[int'(m_lane)*RES_W +: RES_W] = s;
    in_valid = 1'b1; row_addr = r; spare_en = en; core_res = c; spare_res = s;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic apply(input logic [ADDR_W-1:0] r, input logic en,
                       input logic [BUS_W-1:0] c, input logic [RES_W-1:0] s,
                       input string req);
    @(negedge clk);
    cfg_we = 1'b0;
    drive(r, en, c, s, req);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      core_res = {BUS_W{1'b1}};
      spare_res = '1;
    end
  endtask

  // Monitor: a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (mon_on) begin
        if (exp_q.size() > 0) begin
          logic [BUS_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_valid === 1'b1, "R2 out_valid one cycle after input",
                BUS_W'(out_valid), BUS_W'(1));
          check(out_res === e, t, out_res, e);
          last_out = out_res;
        end else begin
          check(out_valid === 1'b0, "R2 no output without input",
                BUS_W'(out_valid), BUS_W'(0));
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] pat;
    rst_n = 1'b0; cfg_we = 0; cfg_valid = 0; spare_en = 0; in_valid = 0;
    cfg_addr = '0; cfg_lane = '0; row_addr = '0; core_res = '0; spare_res = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid in reset", BUS_W'(out_valid), '0);
    check(out_res === '0, "R1 out_res in reset", out_res, '0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    check(out_res === '0, "R1 out_res after reset", out_res, '0);

    // Reset entry: addr 0, invalid. Row 0 with spare on must not substitute.
    apply(9'd0, 1'b1, 64'h0102030405060708, 8'hEE, "R1 R6 reset entry invalid");
    cfg(9'd5, 3'd2, 1'b1);
    apply(9'd5, 1'b1, 64'h1111111111111111, 8'hAB, "R4 lane2 substituted");
    apply(9'd6, 1'b1, 64'h2222222222222222, 8'hAB, "R3 address mismatch");
    apply(9'd5, 1'b0, 64'h3333333333333333, 8'hAB, "R5 spare_en low");
    apply(9'h1FF, 1'b1, 64'hF0E1D2C3B4A59687, 8'h5A, "R3 mismatch top address");
    cfg(9'd5, 3'd0, 1'b1);
    apply(9'd5, 1'b1, 64'h8877665544332211, 8'hCC, "R7 lane0 substituted");
    cfg(9'h1FF, 3'd7, 1'b1);
    apply(9'h1FF, 1'b1, 64'h8877665544332211, 8'hDD, "R7 lane7 substituted");
    apply(9'd5, 1'b1, 64'h8877665544332211, 8'hDD, "R8 old address no longer hits");
    cfg(9'h1FF, 3'd7, 1'b0);
    apply(9'h1FF, 1'b1, 64'h0F0F0F0F0F0F0F0F, 8'h99, "R6 entry invalid");

    // Write, then input on the very next cycle, back to back.
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b1; cfg_addr = 9'd42; cfg_lane = 3'd4; cfg_valid = 1'b1;
    m_addr = 9'd42; m_lane = 3'd4; m_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    drive(9'd42, 1'b1, 64'hAAAAAAAAAAAAAAAA, 8'h3C, "R8 new entry used next cycle");
    for (int i = 0; i < LANES; i++) begin
      pat = '0;
      for (int j = 0; j < LANES; j++) pat[j*RES_W +: RES_W] = RES_W'(16*j + i);
      apply(9'd42, (i % 3) != 0, pat, RES_W'(8'hC0 + i),
            "R4 R7 streamed pattern");
    end
    idle(1);
    @(negedge clk);
    idle(3);
    check(out_res === last_out, "R9 out_res held while idle", out_res, last_out);
    check(exp_q.size() == 0, "R2 every input produced one output",
          BUS_W'(exp_q.size()), '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule